// File: doc/BRIEF.md
# Dual Reload Pulse Generator with Cascade

The block holds two 8-bit down-counting channels. Each one drives a pulse pin whose low phase and high phase lengths come from two separate reload values. A channel's output goes low when it is enabled, and the counter starts from the low-phase value. Each time the counter passes zero, the output flips and the counter reloads from the value for the new phase. A reload value of N therefore gives a phase of N+1 count ticks.

The pair can run in three ways. It can run as two independent 8-bit generators. It can run as one 16-bit generator, where channel 0 holds the low byte and channel 1 holds the high byte. It can also run as an 8-bit prescaler (channel 0) that steps an 8-bit generator (channel 1). A shared clock select gives the count tick. The choices are the system clock, the system clock divided by 2, 4, 8 or 16, or a slow timebase tick every `TB_DIV` cycles.

Software sets up the block through a simple write port. Each channel raises a gated interrupt at the end of every high phase.

Top module: `pulse_pair`

## Requirements
- R1: After reset, `out0`, `out1`, `irq0` and `irq1` are low.
- R2: Register addresses are: 0 = low width of channel 0, 1 = high width of channel 0, 2 = low width of channel 1, 3 = high width of channel 1.
  - In independent mode (control mode field 0), an enabled channel with low value L and high value H holds its pin low for L+1 ticks and high for H+1 ticks, repeating.
  - A disabled channel holds its pin low.
- R3: The clock select field, bits [6:4] of the control register at address 4, chooses the tick period:
  - codes 0 to 4 give a tick every 1, 2, 4, 8 or 16 system clocks;
  - code 5 gives a tick every `TB_DIV` clocks.
- R4: In 16-bit mode (mode field bits [3:2] = 1, enabled by bit 0), `out0` is low for {L1,L0}+1 ticks and high for {H1,H0}+1 ticks. Channel 1 supplies the upper byte. `out1` stays low.
- R5: In prescaler mode (mode field = 2, enabled by bit 1), channel 0 underflows once every L0+1 ticks, and each underflow is one tick for channel 1. So `out1` is low for (L1+1)(L0+1) ticks and high for (H1+1)(L0+1) ticks, and `out0` stays low.
- R6: A width register written during a phase does not change that phase; the new value is used at the next reload from that register.
- R7: A channel's flag sets at the clock edge where its pin falls from high to low. The register at address 5 controls the flags:
  - bits [1:0] are the interrupt enables of channels 0 and 1;
  - writing 1 to bit 4 or bit 5 clears flag 0 or flag 1.

  `irqN` = flagN AND enableN, and a flag set while its interrupt is disabled appears as soon as the enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| out0 | output | 1 | Pulse pin of channel 0 (16-bit result in 16-bit mode) |
| out1 | output | 1 | Pulse pin of channel 1 |
| irq0 | output | 1 | Gated interrupt of channel 0 |
| irq1 | output | 1 | Gated interrupt of channel 1 |

## Verification
A wrong counter value or a wrong reload choice shows up as a phase length that is off. It becomes visible at the very next pin edge, within one phase of (value+1) ticks. A wrong carry between the bytes in 16-bit mode, or a wrong prescaler underflow, stretches or shrinks whole phases by a multiple of the lower count, which the measured widths expose directly. A flag set at the wrong moment, or not cleared, is visible on the interrupt pin in the same cycle as the falling edge or the clearing write.

// File: rtl/pulse_pair.sv
module pulse_pair #(
  parameter int W      = 8,
  parameter int TB_DIV = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         out0,
  output logic         out1,
  output logic         irq0,
  output logic         irq1
);
  localparam int TBW = (TB_DIV > 1) ? $clog2(TB_DIV) : 1;

  logic [W-1:0] lo0, hi0, lo1, hi1, cnt0, cnt1;
  logic         en0, en1, ie0, ie1, fl0, fl1;
  logic [1:0]   mode;
  logic [2:0]   sel;
  logic [3:0]   div;
  logic [TBW-1:0] tb;
  logic         tick;

  wire is16  = (mode == 2'd1);
  wire ispre = (mode == 2'd2);
  wire run0  = ispre ? en1 : en0;
  wire run1  = !is16 && en1;
  wire zero0 = (cnt0 == '0) && (!is16 || cnt1 == '0);
  wire uf0   = run0 && tick && zero0;
  wire tick1 = ispre ? uf0 : tick;
  wire uf1   = run1 && tick1 && (cnt1 == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div <= '0;
      tb  <= '0;
    end else begin
      div <= div + 4'd1;
      tb  <= (tb == TBW'(TB_DIV - 1)) ? '0 : tb + TBW'(1);
    end

  always_comb
    case (sel)
      3'd0:    tick = 1'b1;
      3'd1:    tick = div[0];
      3'd2:    tick = &div[1:0];
      3'd3:    tick = &div[2:0];
      3'd4:    tick = &div;
      3'd5:    tick = (tb == TBW'(TB_DIV - 1));
      default: tick = 1'b0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lo0 <= '0; hi0 <= '0; lo1 <= '0; hi1 <= '0;
      en0 <= 1'b0; en1 <= 1'b0; mode <= '0; sel <= '0;
      ie0 <= 1'b0; ie1 <= 1'b0; fl0 <= 1'b0; fl1 <= 1'b0;
    end else begin
      if (wr_en)
        case (wr_addr)
          3'd0: lo0 <= wr_data;
          3'd1: hi0 <= wr_data;
          3'd2: lo1 <= wr_data;
          3'd3: hi1 <= wr_data;
          3'd4: {sel, mode, en1, en0} <= wr_data[6:0];
          3'd5: {ie1, ie0} <= wr_data[1:0];
          default: ;
        endcase
      if (uf0 && out0 && !ispre)                    fl0 <= 1'b1;
      else if (wr_en && wr_addr == 3'd5 && wr_data[4]) fl0 <= 1'b0;
      if (uf1 && out1)                              fl1 <= 1'b1;
      else if (wr_en && wr_addr == 3'd5 && wr_data[5]) fl1 <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt0 <= '0;
      out0 <= 1'b0;
    end else begin
      if (!run0) begin
        cnt0 <= lo0;
        out0 <= 1'b0;
      end else if (tick) begin
        if (zero0) begin
          cnt0 <= (ispre || out0) ? lo0 : hi0;
          out0 <= !out0;
        end else begin
          cnt0 <= cnt0 - 1'b1;
        end
      end
      if (ispre) out0 <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt1 <= '0;
      out1 <= 1'b0;
    end else if (is16) begin
      out1 <= 1'b0;
      if (!run0)
        cnt1 <= lo1;
      else if (tick) begin
        if (zero0)              cnt1 <= out0 ? lo1 : hi1;
        else if (cnt0 == '0)    cnt1 <= cnt1 - 1'b1;
      end
    end else if (!run1) begin
      cnt1 <= lo1;
      out1 <= 1'b0;
    end else if (tick1) begin
      if (cnt1 == '0) begin
        cnt1 <= out1 ? lo1 : hi1;
        out1 <= !out1;
      end else begin
        cnt1 <= cnt1 - 1'b1;
      end
    end

  assign irq0 = fl0 && ie0;
  assign irq1 = fl1 && ie1;
endmodule

// File: rtl/pulse_pair_chk.sv
module pulse_pair_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         is16,
  input logic         ispre,
  input logic         run0,
  input logic         tick,
  input logic [W-1:0] cnt0,
  input logic         out0,
  input logic         out1,
  input logic         fl0
);
  AST_TOGGLE_ONLY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run0 && tick && cnt0 != '0 && !is16 && !ispre) |=> $stable(out0)); // R2

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run0 && !tick && !ispre) |=> $stable(out0)); // R3

  AST_WIDE_OUT1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    is16 |=> !out1); // R4

  AST_PRESCALE_OUT0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ispre |=> !out0); // R5

  AST_FLAG_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl0) |-> $fell(out0)); // R7
endmodule

bind pulse_pair pulse_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .is16(is16), .ispre(ispre), .run0(run0),
  .tick(tick), .cnt0(cnt0), .out0(out0), .out1(out1), .fl0(fl0)
);

// File: tb/sim_pulse_pair.sv
module sim_pulse_pair;
  localparam int TBD = 40;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic out0, out1, irq0, irq1;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pulse_pair #(.W(8), .TB_DIV(TBD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out0(out0), .out1(out1), .irq0(irq0), .irq1(irq1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctrl(input int e0, input int e1, input int md, input int sl);
    wr(4, (sl << 4) | (md << 2) | (e1 << 1) | e0);
  endtask

  function automatic logic pin(input int ch);
    return ch != 0 ? out1 : out0;
  endfunction

  task automatic wait_lvl(input int ch, input logic v);
    for (int g = 0; g < 100000 && pin(ch) != v; g++) @(negedge clk);
  endtask

  task automatic measure(input int ch, output int hi, output int lo);
    int n;
    wait_lvl(ch, 1'b0);
    wait_lvl(ch, 1'b1);
    n = 0;
    while (pin(ch)) begin n++; @(negedge clk); end
    hi = n;
    n = 0;
    while (!pin(ch)) begin n++; @(negedge clk); end
    lo = n;
  endtask

  task automatic setup(input int l0, input int h0, input int l1, input int h1);
    ctrl(0, 0, 0, 0);
    wr(0, l0); wr(1, h0); wr(2, l1); wr(3, h1);
  endtask

  initial begin
    #(20 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int hi, lo;
    repeat (3) @(negedge clk);
    chk(out0 == 0 && out1 == 0, "R1 pins after reset", {out1, out0}, 0);
    chk(irq0 == 0 && irq1 == 0, "R1 irqs after reset", {irq1, irq0}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: sweep of independent widths on both channels
    for (int v = 0; v < 256; v += 15) begin
      setup(v, 255 - v, (v * 7) & 255, v / 3);
      ctrl(1, 1, 0, 0);
      measure(0, hi, lo);
      chk(hi == 256 - v, "R2 ch0 high", hi, 256 - v);
      chk(lo == v + 1, "R2 ch0 low", lo, v + 1);
      measure(1, hi, lo);
      chk(hi == v / 3 + 1, "R2 ch1 high", hi, v / 3 + 1);
      chk(lo == ((v * 7) & 255) + 1, "R2 ch1 low", lo, ((v * 7) & 255) + 1);
    end
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        setup(a, b, b, a);
        ctrl(1, 1, 0, 0);
        measure(0, hi, lo);
        chk(hi == b + 1 && lo == a + 1, "R2 ch0 small", hi * 1000 + lo, (b + 1) * 1000 + a + 1);
        measure(1, hi, lo);
        chk(hi == a + 1 && lo == b + 1, "R2 ch1 small", hi * 1000 + lo, (a + 1) * 1000 + b + 1);
      end
    setup(3, 3, 3, 3);
    ctrl(0, 1, 0, 0);
    repeat (30) @(negedge clk);
    chk(out0 == 0, "R2 disabled channel low", out0, 0);

    // R3: clock select codes
    for (int s = 0; s < 6; s++) begin
      int p;
      p = (s == 5) ? TBD : (1 << s);
      setup(3, 5, 0, 0);
      ctrl(1, 0, 0, s);
      measure(0, hi, lo);
      chk(hi == 6 * p, "R3 high with select", hi, 6 * p);
      chk(lo == 4 * p, "R3 low with select", lo, 4 * p);
    end

    // R4: 16-bit mode, including byte carry
    setup(8'h02, 8'h05, 8'h01, 8'h00);
    ctrl(1, 0, 1, 0);
    measure(0, hi, lo);
    chk(hi == 6, "R4 16-bit high", hi, 6);
    chk(lo == 259, "R4 16-bit low", lo, 259);
    chk(out1 == 0, "R4 out1 idle", out1, 0);
    setup(8'h00, 8'h10, 8'h01, 8'h02);
    ctrl(1, 1, 1, 1);
    measure(0, hi, lo);
    chk(hi == 2 * 529, "R4 16-bit high div2", hi, 2 * 529);
    chk(lo == 2 * 257, "R4 16-bit low div2", lo, 2 * 257);
    chk(out1 == 0, "R4 out1 idle div2", out1, 0);

    // R5: prescaler mode
    setup(2, 9, 3, 1);
    ctrl(0, 1, 2, 0);
    measure(1, hi, lo);
    chk(hi == 6, "R5 prescaled high", hi, 6);
    chk(lo == 12, "R5 prescaled low", lo, 12);
    chk(out0 == 0, "R5 out0 idle", out0, 0);
    setup(4, 0, 0, 2);
    ctrl(0, 1, 2, 2);
    measure(1, hi, lo);
    chk(hi == 60, "R5 prescaled high div4", hi, 60);
    chk(lo == 20, "R5 prescaled low div4", lo, 20);

    // R6: write during a high phase applies at the next reload
    setup(4, 6, 0, 0);
    ctrl(1, 0, 0, 0);
    wait_lvl(0, 1'b0);
    wait_lvl(0, 1'b1);
    begin
      int n;
      n = 1;
      wr(1, 10);
      while (out0) begin n++; @(negedge clk); end
      chk(n == 7, "R6 current high unchanged", n, 7);
    end
    measure(0, hi, lo);
    chk(hi == 11, "R6 next high uses new value", hi, 11);
    chk(lo == 5, "R6 low unaffected", lo, 5);

    // R7: interrupt flags
    setup(3, 3, 2, 2);
    wr(5, 8'h33);
    wr(5, 8'h03);
    ctrl(1, 1, 0, 0);
    wait_lvl(0, 1'b1);
    wait_lvl(0, 1'b0);
    chk(irq0 == 1, "R7 irq0 on fall", irq0, 1);
    wr(5, 8'h13);
    chk(irq0 == 0, "R7 irq0 cleared", irq0, 0);
    wait_lvl(1, 1'b1);
    wait_lvl(1, 1'b0);
    chk(irq1 == 1, "R7 irq1 on fall", irq1, 1);
    wr(5, 8'h30);
    chk(irq1 == 0 && irq0 == 0, "R7 cleared and gated", {irq1, irq0}, 0);
    wait_lvl(0, 1'b1);
    wait_lvl(0, 1'b0);
    chk(irq0 == 0, "R7 gated fall", irq0, 0);
    wr(5, 8'h01);
    chk(irq0 == 1, "R7 pending flag shows on enable", irq0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule